// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

This block turns the two digital outputs of an ARINC 429 line receiver into whole 32-bit words. A high on the "one" line marks a received One and a high on the "zero" line marks a received Zero. The OR of the two lines acts as the bit clock, and the "one" line gives the bit value. A pair of test inputs can drive the same path directly in place of the line receiver. Bits are shifted into an input register in the order they arrive.

A word ends when no bit has been seen for a fixed number of rising edges of a slow external gap clock. At that point the block checks the bit count. If parity checking is on, it also checks the word for odd parity. It then hands the word, a one-cycle load strobe and an error flag to a downstream receive buffer. All logic runs on one system clock. The line, test and gap-clock inputs are asynchronous and are synchronised on entry. After reset the receiver ignores the line until it has seen one full gap, so it never captures the tail of a word.

Top module: `a429_rx_core`

## Requirements
- R1: A pulse on `line_a` is a One and a pulse on `line_b` is a Zero. Each rising edge of their OR shifts in one bit. The first bit received ends up in `word_o[0]` and the 32nd in `word_o[31]`.
- R2: While `tst_a` or `tst_b` is high, the test pair replaces the line pair. (1,0) is a One, (0,1) is a Zero and (1,1) is a null.
- R3: A word ends only after 16 rising edges of `gap_clk` with no bit received. Before that, no load and no flag change takes place.
- R4: At a gap that follows exactly 32 bits, `load_o` pulses high for one cycle and `word_o` takes the new word.
- R5: At a gap that follows fewer or more than 32 bits, `err_o` goes high, `load_o` stays low and `word_o` keeps its previous value.
- R6: A load with no parity failure returns `err_o` low.
- R7: With `parity_en` high, a 32-bit word with an even number of ones is still loaded. Its bit 31 is forced to 1 and `err_o` goes high. A word with odd parity is loaded unchanged.
- R8: With `parity_en` low, bit 31 is the 32nd bit received and parity never raises `err_o`.
- R9: While `rst_n` is low, `word_o`, `load_o` and `err_o` are 0. After release, bits that arrive before the first detected gap are discarded.
- R10: The bit count saturates above 32, so a word of 96 bits still reports a length error instead of wrapping to an apparent 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_a | input | 1 | Line receiver "one" output (asynchronous) |
| line_b | input | 1 | Line receiver "zero" output (asynchronous) |
| tst_a | input | 1 | Test "one" input (asynchronous) |
| tst_b | input | 1 | Test "zero" input (asynchronous) |
| gap_clk | input | 1 | Slow gap timing clock (asynchronous) |
| parity_en | input | 1 | Enables the odd-parity check |
| word_o | output | 32 | Last word loaded, first-arrived bit in bit 0 |
| load_o | output | 1 | One-cycle strobe when `word_o` takes a new word |
| err_o | output | 1 | Length or parity error flag |

## Verification
The bench targets bit ordering at both ends of the word. A reversed shift would put a lone first bit in bit 31 instead of bit 0. It also covers short and long words. A design that loads on any gap, or whose counter wraps, would pulse the load and overwrite the buffer after 96 bits. Parity is tested with bit 31 received as 0, so a missing force-high or a wrong parity sense shows up in the word. Further cases are a word sent right after reset, which a receiver that is not held off would load, a probe part-way into the gap timeout to catch an early end of word, and test-pair words with null spacing, where a decoder that treats (1,1) as a bit would corrupt the count.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  // Bits in one complete word
  localparam int WORD_BITS   = 32;
  // Gap clock rising edges with no bit that mark the end of a word
  localparam int GAP_TICKS   = 16;
  // Flops in each input synchroniser
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/a429_rx_sync.sv
module a429_rx_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stg_d = d;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/a429_rx_front.sv
module a429_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_a,
  input  logic line_b,
  input  logic tst_a,
  input  logic tst_b,
  output logic bit_stb,
  output logic bit_val
);
  logic       test_mode;
  logic [1:0] raw_ab;
  logic [1:0] sync_ab;
  logic       bclk;
  logic       bclk_q;

  // Test pair overrides the line pair; both high is a null
  always_comb begin
    test_mode = tst_a | tst_b;
    if (test_mode) raw_ab = {tst_a & ~tst_b, tst_b & ~tst_a};
    else           raw_ab = {line_a, line_b};
  end

  a429_rx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_ab),
    .q     (sync_ab)
  );

  assign bclk = sync_ab[1] | sync_ab[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  assign bit_stb = bclk & ~bclk_q;
  assign bit_val = sync_ab[1];
endmodule

// File: rtl/a429_rx_gap.sv
module a429_rx_gap #(
  parameter int GAP_TICKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gap_clk,
  input  logic bit_stb,
  output logic gap_stb
);
  localparam int GW = $clog2(GAP_TICKS + 1);
  localparam logic [GW-1:0] LAST = GW'(GAP_TICKS - 1);

  logic          gclk_s;
  logic          gclk_q;
  logic          gtick;
  logic [GW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          cnt_en;

  a429_rx_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_g (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (gap_clk),
    .q     (gclk_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gclk_q <= 1'b0;
    else        gclk_q <= gclk_s;
  end

  assign gtick = gclk_s & ~gclk_q;

  // A bit restarts the timeout; one gap is flagged per idle stretch
  always_comb begin
    cnt_d   = cnt_q;
    done_d  = done_q;
    gap_stb = 1'b0;
    cnt_en  = 1'b0;
    if (bit_stb) begin
      cnt_d  = '0;
      done_d = 1'b0;
      cnt_en = 1'b1;
    end else if (gtick && !done_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        done_d  = 1'b1;
        gap_stb = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/a429_rx_frame.sv
module a429_rx_frame #(
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_stb,
  input  logic                 bit_val,
  input  logic                 gap_stb,
  input  logic                 parity_en,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 load_o,
  output logic                 err_o
);
  localparam int CW = $clog2(WORD_BITS + 2);
  localparam logic [CW-1:0] FULL = CW'(WORD_BITS);
  localparam logic [CW-1:0] SAT  = CW'(WORD_BITS + 1);

  logic                 armed_q, armed_d;
  logic [WORD_BITS-1:0] sreg_q, sreg_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [WORD_BITS-1:0] word_q, word_d;
  logic                 load_q, load_d;
  logic                 err_q, err_d;
  logic                 par_bad;

  assign par_bad = parity_en & ~(^sreg_q);

  always_comb begin
    armed_d = armed_q;
    sreg_d  = sreg_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    load_d  = 1'b0;
    err_d   = err_q;
    if (gap_stb) begin
      armed_d = 1'b1;
      sreg_d  = '0;
      cnt_d   = '0;
      if (armed_q) begin
        if (cnt_q == FULL) begin
          load_d                = 1'b1;
          word_d                = sreg_q;
          word_d[WORD_BITS-1]   = sreg_q[WORD_BITS-1] | par_bad;
          err_d                 = par_bad;
        end else begin
          err_d = 1'b1;
        end
      end
    end else if (bit_stb && armed_q) begin
      sreg_d = {bit_val, sreg_q[WORD_BITS-1:1]};
      if (cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      sreg_q  <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      sreg_q  <= sreg_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      load_q  <= load_d;
      err_q   <= err_d;
    end
  end

  assign word_o = word_q;
  assign load_o = load_q;
  assign err_o  = err_q;
endmodule

// File: rtl/a429_rx_core.sv
module a429_rx_core
  import a429_rx_pkg::*;
#(
  parameter int P_WORD_BITS   = WORD_BITS,
  parameter int P_GAP_TICKS   = GAP_TICKS,
  parameter int P_SYNC_STAGES = SYNC_STAGES
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   line_a,
  input  logic                   line_b,
  input  logic                   tst_a,
  input  logic                   tst_b,
  input  logic                   gap_clk,
  input  logic                   parity_en,
  output logic [P_WORD_BITS-1:0] word_o,
  output logic                   load_o,
  output logic                   err_o
);
  logic bit_stb;
  logic bit_val;
  logic gap_stb;

  a429_rx_front #(.SYNC_STAGES(P_SYNC_STAGES)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_a  (line_a),
    .line_b  (line_b),
    .tst_a   (tst_a),
    .tst_b   (tst_b),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  a429_rx_gap #(.GAP_TICKS(P_GAP_TICKS), .SYNC_STAGES(P_SYNC_STAGES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .gap_clk (gap_clk),
    .bit_stb (bit_stb),
    .gap_stb (gap_stb)
  );

  a429_rx_frame #(.WORD_BITS(P_WORD_BITS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .gap_stb   (gap_stb),
    .parity_en (parity_en),
    .word_o    (word_o),
    .load_o    (load_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         parity_en,
  input logic [W-1:0] word_o,
  input logic         load_o,
  input logic         err_o
);
  // R4: the load strobe lasts a single cycle
  assert_load_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);

  // R5: the word output moves only together with a load
  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_o |-> $stable(word_o));

  // R8 and R6: a load with parity off leaves the error flag low
  assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && !$past(parity_en)) |-> !err_o);

  // R7: a clean load under parity checking carries odd parity
  assert_parity_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && $past(parity_en) && !err_o) |-> (^word_o));

  // R9: outputs are quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R9: assert (!load_o && !err_o && (word_o == '0));
    end
  end
endmodule

bind a429_rx_core a429_rx_chk #(.W(P_WORD_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .parity_en (parity_en),
  .word_o    (word_o),
  .load_o    (load_o),
  .err_o     (err_o)
);

// File: tb/a429_rx_core_tb.sv
module a429_rx_core_tb;
  logic        clk;
  logic        rst_n;
  logic        line_a, line_b, tst_a, tst_b, gap_clk, parity_en;
  logic [31:0] word_o;
  logic        load_o, err_o;

  int total = 0;
  int bad   = 0;
  int nload = 0;
  bit done  = 0;

  a429_rx_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_a    (line_a),
    .line_b    (line_b),
    .tst_a     (tst_a),
    .tst_b     (tst_b),
    .gap_clk   (gap_clk),
    .parity_en (parity_en),
    .word_o    (word_o),
    .load_o    (load_o),
    .err_o     (err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Gap clock: period of 8 system clocks
  initial gap_clk = 1'b0;
  always #40 gap_clk = ~gap_clk;

  always @(negedge clk) if (load_o) nload++;

  typedef struct packed {
    logic [31:0] w;
    logic [6:0]  n;
    logic        pe;
    logic        tm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0001, 7'd32, 1'b0, 1'b0},  // R1 first bit in bit 0
    '{32'h8000_0000, 7'd32, 1'b0, 1'b0},  // R1 last bit in bit 31
    '{32'h1234_5678, 7'd20, 1'b0, 1'b0},  // R5 short
    '{32'h0000_0003, 7'd32, 1'b1, 1'b0},  // R7 even parity
    '{32'h0000_0007, 7'd32, 1'b1, 1'b0},  // R6 clears, R7 odd
    '{32'h0000_0003, 7'd32, 1'b0, 1'b0},  // R8 parity off
    '{32'h55AA_33CC, 7'd33, 1'b0, 1'b0},  // R5 long
    '{32'hCAFE_F00D, 7'd32, 1'b0, 1'b1},  // R2 test pair
    '{32'h0F0F_F0F0, 7'd40, 1'b0, 1'b1},  // R2 long in test mode
    '{32'h7654_3210, 7'd32, 1'b1, 1'b1}   // R2 with parity
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic v, input logic tm);
    if (tm) begin tst_a = v; tst_b = ~v; end
    else    begin line_a = v; line_b = ~v; end
    cyc(3);
    if (tm) begin tst_a = 1'b1; tst_b = 1'b1; end
    else    begin line_a = 1'b0; line_b = 1'b0; end
    cyc(3);
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input logic tm);
    if (tm) begin tst_a = 1'b1; tst_b = 1'b1; cyc(4); end
    for (int i = 0; i < n; i++) send_bit((i < 32) ? w[i] : 1'b0, tm);
  endtask

  task automatic leave_test();
    tst_a = 1'b0; tst_b = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev_word;
    logic [31:0] ew;
    logic        ee, el, pbad;
    int          l0;

    rst_n = 1'b0; line_a = 0; line_b = 0; tst_a = 0; tst_b = 0; parity_en = 0;
    cyc(4);
    // R9 reset state
    check(word_o == 0 && !load_o && !err_o, "R9 reset outputs", {word_o[31:2], load_o, err_o}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);

    // R9 word arriving before the first gap is dropped
    l0 = nload;
    send_word(32'hFFFF_0000, 32, 1'b0);
    cyc(200);
    check(nload == l0, "R9 pre-gap word not loaded", nload - l0, 0);
    check(!err_o && word_o == 0, "R9 pre-gap word no effect", word_o, 32'd0);

    // R3 timeout: no load part-way, load after full gap
    l0 = nload;
    send_word(32'h0000_00F0, 32, 1'b0);
    cyc(100);
    check(nload == l0, "R3 no load before 16 gap ticks", nload - l0, 0);
    cyc(100);
    check(nload == l0 + 1 && word_o == 32'h0000_00F0, "R3 load after gap", word_o, 32'h0000_00F0);
    prev_word = word_o;

    // Table walk
    for (int k = 0; k < NV; k++) begin
      parity_en = VEC[k].pe;
      l0 = nload;
      send_word(VEC[k].w, int'(VEC[k].n), VEC[k].tm);
      if (VEC[k].tm) leave_test();
      cyc(200);
      el   = (VEC[k].n == 7'd32);
      pbad = VEC[k].pe && !(^VEC[k].w);
      ee   = !el || pbad;
      ew   = el ? (VEC[k].w | (pbad ? 32'h8000_0000 : 32'h0)) : prev_word;
      check((nload - l0) == (el ? 1 : 0), $sformatf("R4/R5 load count vec %0d", k), nload - l0, el ? 1 : 0);
      check(err_o == ee, $sformatf("R5/R6/R7/R8 err vec %0d", k), {31'd0, err_o}, {31'd0, ee});
      check(word_o == ew, $sformatf("R1/R2/R7/R8 word vec %0d", k), word_o, ew);
      prev_word = ew;
    end
    parity_en = 1'b0;

    // R10 96 bits must not wrap to an apparent 32
    l0 = nload;
    send_word(32'hAAAA_AAAA, 96, 1'b0);
    cyc(200);
    check(nload == l0, "R10 96-bit word not loaded", nload - l0, 0);
    check(err_o == 1'b1, "R10 96-bit word flagged", {31'd0, err_o}, 32'd1);
    check(word_o == prev_word, "R10 word kept", word_o, prev_word);

    // R6 a clean word clears the flag
    send_word(32'h0000_0100, 32, 1'b0);
    cyc(200);
    check(!err_o && word_o == 32'h0000_0100, "R6 clean word clears err", word_o, 32'h0000_0100);

    // R9 reset clears a raised flag
    send_word(32'h0000_0001, 5, 1'b0);
    cyc(200);
    check(err_o == 1'b1, "R5 short word flagged", {31'd0, err_o}, 32'd1);
    @(negedge clk); rst_n = 1'b0;
    cyc(2);
    check(!err_o && word_o == 0, "R9 reset clears err and word", word_o, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule